// File: doc/BRIEF.md
# Scheduler-Directed Dirty Line Cleaner

This block decides which dirty line of a set-associative last-level cache is written back to DRAM next. The memory write scheduler drives that choice, not cache replacement. The block keeps a shadow copy of the directory's dirty, replacement-half and tag state for every line. It also keeps a per-set summary of the lines that may be cleaned: dirty, in the least-recently-used half of the ways, and not already on their way out. Each cycle it searches this summary against a snapshot of the physical write queue. The aim is to keep that queue stocked with writes that suit the DRAM: writes that open no new row in a busy bank, and writes spread evenly over the ranks.

The set index holds every rank-select and bank-select bit, so the DRAM resource of a line follows from its set alone. A line whose bank already has a queued write to another row is never chosen. A line whose row is already queued in its bank is chosen first, so writes to the same page are grouped. Otherwise the block picks a line that targets an idle bank, in the rank that has the fewest queued writes. When no line qualifies, no request is made. A chosen line is held as pending until the queue accepts the write, and the acceptance clears its dirty state.

Top module: `dirty_cleaner`

## Requirements
- R1: After reset, `req_valid` is 0 and no line is dirty, so no request appears even with `q_free` high.
- R2: A line is a cleaning candidate only if its last update set it dirty with `upd_lru_half` = 1 and it is not pending. A dirty line in the most-recently-used half, or a clean line, is never requested.
- R3: A request is issued only in a cycle where `q_free` is 1 and no request is outstanding. At most one request is outstanding at a time, and it appears on the cycle after the issuing edge.
- R4: An outstanding request keeps `req_set`, `req_way` and `req_addr` stable until `req_ack`. `req_addr` is {line tag, set index}.
- R5: A request accepted by `req_ack` drops `req_valid` on the next cycle and clears that line's dirty state, so the line is not requested again.
- R6: The DRAM resource of set s is s[2:0] with defaults: bank = s[1:0], rank = s[2]. Bit s[3] is a column bit. A line is never chosen when its resource has a nonzero queued count in `q_cnt` and a queued row in `q_row` that differs from the line tag.
- R7: A candidate whose resource has queued writes with a row equal to its tag (page hit) is chosen over any candidate that targets an idle bank.
- R8: Without page hits, the block picks a candidate targeting an idle bank (queued count 0). It takes it from the rank with the smallest sum of queued counts over that rank's banks, among ranks that have such a candidate.
- R9: Ties between ranks in R8 go to the first rank in order from a round-robin pointer. The pointer is 0 after reset and, after each idle-bank issue, moves to the rank after the one chosen. Page-hit issues leave it unchanged.
- R10: Within the chosen tier (page hit, or the chosen rank), the lowest set index wins, then the lowest way.
- R11: When every candidate conflicts under R6, or no candidate exists, `req_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Directory update strobe |
| upd_set | input | 4 | Set of the updated line |
| upd_way | input | 2 | Way of the updated line |
| upd_dirty | input | 1 | New dirty state of the line |
| upd_lru_half | input | 1 | Line now sits in the LRU half of its set |
| upd_tag | input | 4 | Tag (DRAM row) of the line |
| q_free | input | 1 | Physical write queue has a free slot |
| q_cnt | input | 24 | Queued write count per resource, 3 bits each, resource r at [3r+2:3r] |
| q_row | input | 32 | Queued row per resource, 4 bits each, resource r at [4r+3:4r] |
| req_ack | input | 1 | Queue accepts the outstanding request |
| req_valid | output | 1 | Writeback request outstanding |
| req_set | output | 4 | Set of the requested line |
| req_way | output | 2 | Way of the requested line |
| req_addr | output | 8 | Line address {tag, set} |

## Verification
The selection is driven with pairs of cleanable lines against queue snapshots that each isolate one rule. A page hit is set against an idle bank, which separates the row-match tier from the idle tier. Lines that conflict by row sit alone or beside an idle-bank line, which shows conflicting lines are skipped rather than merely ranked low. Unequal rank loads, in both directions, show that rank load matters and not a fixed rank order. Pairs in the same rank and in the same set tell set order from way order. Directed sequences then cover ignored lines (clean, or in the MRU half), a closed queue, holding a request until it is accepted, and a four-line drain that exposes the rank rotation.

// File: rtl/cln_pkg.sv
package cln_pkg;

  // Which selection tier produced the current choice.
  typedef enum logic [1:0] {
    TIER_NONE = 2'd0,
    TIER_PAGE = 2'd1,
    TIER_IDLE = 2'd2
  } cln_tier_e;

endpackage

// File: rtl/cln_line_state.sv
module cln_line_state #(
  parameter int SET_W = 4,
  parameter int WAY_W = 2,
  parameter int TAG_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           upd_v,
  input  logic [SET_W-1:0]               upd_set,
  input  logic [WAY_W-1:0]               upd_way,
  input  logic                           upd_dirty,
  input  logic                           upd_lru_half,
  input  logic [TAG_W-1:0]               upd_tag,
  input  logic                           iss_v,
  input  logic [SET_W-1:0]               iss_set,
  input  logic [WAY_W-1:0]               iss_way,
  input  logic                           ack_v,
  input  logic [SET_W-1:0]               ack_set,
  input  logic [WAY_W-1:0]               ack_way,
  output logic [(1<<(SET_W+WAY_W))-1:0]  elig_o,
  output logic [(1<<(SET_W+WAY_W))*TAG_W-1:0] tag_o,
  output logic [(1<<SET_W)-1:0]          summary_o
);

  localparam int SETS   = 1 << SET_W;
  localparam int WAYS   = 1 << WAY_W;
  localparam int LINE_W = SET_W + WAY_W;
  localparam int LINES  = 1 << LINE_W;

  logic [LINES-1:0]       dirty_q, dirty_d;
  logic [LINES-1:0]       lru_q, lru_d;
  logic [LINES-1:0]       pend_q, pend_d;
  logic [LINES*TAG_W-1:0] tag_q, tag_d;
  logic                   st_en;

  logic [LINE_W-1:0] upd_idx, iss_idx, ack_idx;
  assign upd_idx = {upd_set, upd_way};
  assign iss_idx = {iss_set, iss_way};
  assign ack_idx = {ack_set, ack_way};
  assign st_en   = upd_v | iss_v | ack_v;

  // Next state: acceptance first, then issue, then directory update wins.
  always_comb begin
    dirty_d = dirty_q;
    lru_d   = lru_q;
    pend_d  = pend_q;
    tag_d   = tag_q;
    if (ack_v) begin
      dirty_d[ack_idx] = 1'b0;
      pend_d[ack_idx]  = 1'b0;
    end
    if (iss_v) begin
      pend_d[iss_idx] = 1'b1;
    end
    if (upd_v) begin
      dirty_d[upd_idx]               = upd_dirty;
      lru_d[upd_idx]                 = upd_lru_half;
      tag_d[upd_idx*TAG_W +: TAG_W]  = upd_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q <= '0;
      lru_q   <= '0;
      pend_q  <= '0;
      tag_q   <= '0;
    end else if (st_en) begin
      dirty_q <= dirty_d;
      lru_q   <= lru_d;
      pend_q  <= pend_d;
      tag_q   <= tag_d;
    end
  end

  assign elig_o = dirty_q & lru_q & ~pend_q;
  assign tag_o  = tag_q;

  for (genvar s = 0; s < SETS; s++) begin : g_sum
    assign summary_o[s] = |elig_o[s*WAYS +: WAYS];
  end

  // R5: an accepted line is no longer a candidate unless rewritten the same cycle.
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_v && !(upd_v && (upd_idx == ack_idx))) |=> !elig_o[$past(ack_idx)]);

endmodule

// File: rtl/cln_pick.sv
module cln_pick
  import cln_pkg::*;
#(
  parameter int SET_W  = 4,
  parameter int WAY_W  = 2,
  parameter int TAG_W  = 4,
  parameter int RANK_W = 1,
  parameter int BANK_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic [(1<<(SET_W+WAY_W))-1:0]        elig_i,
  input  logic [(1<<(SET_W+WAY_W))*TAG_W-1:0]  tag_i,
  input  logic [(1<<SET_W)-1:0]                summary_i,
  input  logic [(1<<(RANK_W+BANK_W))*CNT_W-1:0] q_cnt_i,
  input  logic [(1<<(RANK_W+BANK_W))*TAG_W-1:0] q_row_i,
  input  logic [RANK_W-1:0]                    rr_i,
  output logic                                 pick_v,
  output logic [SET_W-1:0]                     pick_set,
  output logic [WAY_W-1:0]                     pick_way,
  output cln_tier_e                            pick_tier,
  output logic [RANK_W-1:0]                    pick_rank
);

  localparam int SETS   = 1 << SET_W;
  localparam int WAYS   = 1 << WAY_W;
  localparam int RES_W  = RANK_W + BANK_W;
  localparam int NRANK  = 1 << RANK_W;
  localparam int BPR    = 1 << BANK_W;
  localparam int RSUM_W = CNT_W + BANK_W;

  logic                      hit_v;
  logic [SET_W-1:0]          hit_set;
  logic [WAY_W-1:0]          hit_way;
  logic [NRANK-1:0]          rc_v;
  logic [SET_W-1:0]          rc_set [NRANK];
  logic [WAY_W-1:0]          rc_way [NRANK];
  logic [RSUM_W-1:0]         rsum   [NRANK];

  // Scan candidates in ascending set, then way, order.
  always_comb begin
    logic [RES_W-1:0]  res;
    logic [RANK_W-1:0] rk;
    logic [CNT_W-1:0]  cnt;
    logic [TAG_W-1:0]  row;
    hit_v   = 1'b0;
    hit_set = '0;
    hit_way = '0;
    rc_v    = '0;
    for (int r = 0; r < NRANK; r++) begin
      rc_set[r] = '0;
      rc_way[r] = '0;
    end
    for (int s = 0; s < SETS; s++) begin
      res = RES_W'(s);
      rk  = res[RES_W-1:BANK_W];
      cnt = q_cnt_i[res*CNT_W +: CNT_W];
      row = q_row_i[res*TAG_W +: TAG_W];
      if (summary_i[s]) begin
        for (int w = 0; w < WAYS; w++) begin
          if (elig_i[s*WAYS + w]) begin
            if (cnt != '0) begin
              if ((row == tag_i[(s*WAYS + w)*TAG_W +: TAG_W]) && !hit_v) begin
                hit_v   = 1'b1;
                hit_set = SET_W'(s);
                hit_way = WAY_W'(w);
              end
            end else if (!rc_v[rk]) begin
              rc_v[rk]   = 1'b1;
              rc_set[rk] = SET_W'(s);
              rc_way[rk] = WAY_W'(w);
            end
          end
        end
      end
    end
  end

  // Queued load per rank.
  always_comb begin
    for (int r = 0; r < NRANK; r++) begin
      rsum[r] = '0;
      for (int b = 0; b < BPR; b++) begin
        rsum[r] = rsum[r] + RSUM_W'(q_cnt_i[(r*BPR + b)*CNT_W +: CNT_W]);
      end
    end
  end

  // Least loaded rank, ties resolved from the round-robin pointer.
  logic              rk_found;
  logic [RANK_W-1:0] rk_best;
  always_comb begin
    logic [RANK_W-1:0] r;
    rk_found = 1'b0;
    rk_best  = '0;
    for (int k = 0; k < NRANK; k++) begin
      r = rr_i + RANK_W'(k);
      if (rc_v[r] && (!rk_found || (rsum[r] < rsum[rk_best]))) begin
        rk_found = 1'b1;
        rk_best  = r;
      end
    end
  end

  always_comb begin
    pick_v    = 1'b0;
    pick_set  = '0;
    pick_way  = '0;
    pick_tier = TIER_NONE;
    pick_rank = '0;
    if (hit_v) begin
      pick_v    = 1'b1;
      pick_set  = hit_set;
      pick_way  = hit_way;
      pick_tier = TIER_PAGE;
      pick_rank = hit_set[RES_W-1:BANK_W];
    end else if (rk_found) begin
      pick_v    = 1'b1;
      pick_set  = rc_set[rk_best];
      pick_way  = rc_way[rk_best];
      pick_tier = TIER_IDLE;
      pick_rank = rk_best;
    end
  end

endmodule

// File: rtl/dirty_cleaner.sv
module dirty_cleaner
  import cln_pkg::*;
#(
  parameter int SET_W  = 4,
  parameter int WAY_W  = 2,
  parameter int TAG_W  = 4,
  parameter int RANK_W = 1,
  parameter int BANK_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   upd_valid,
  input  logic [SET_W-1:0]                       upd_set,
  input  logic [WAY_W-1:0]                       upd_way,
  input  logic                                   upd_dirty,
  input  logic                                   upd_lru_half,
  input  logic [TAG_W-1:0]                       upd_tag,
  input  logic                                   q_free,
  input  logic [(1<<(RANK_W+BANK_W))*CNT_W-1:0]  q_cnt,
  input  logic [(1<<(RANK_W+BANK_W))*TAG_W-1:0]  q_row,
  input  logic                                   req_ack,
  output logic                                   req_valid,
  output logic [SET_W-1:0]                       req_set,
  output logic [WAY_W-1:0]                       req_way,
  output logic [TAG_W+SET_W-1:0]                 req_addr
);

  localparam int LINES = 1 << (SET_W + WAY_W);
  localparam int SETS  = 1 << SET_W;
  localparam int RES_W = RANK_W + BANK_W;

  logic [LINES-1:0]       elig;
  logic [LINES*TAG_W-1:0] tags;
  logic [SETS-1:0]        summary;

  logic              pick_v;
  logic [SET_W-1:0]  pick_set;
  logic [WAY_W-1:0]  pick_way;
  cln_tier_e         pick_tier;
  logic [RANK_W-1:0] pick_rank;

  logic                   req_v_q, req_v_d;
  logic [SET_W-1:0]       req_set_q, req_set_d;
  logic [WAY_W-1:0]       req_way_q, req_way_d;
  logic [TAG_W-1:0]       req_tag_q, req_tag_d;
  logic [RANK_W-1:0]      rr_q, rr_d;
  logic                   issue, ack_fire, req_en;
  logic [TAG_W-1:0]       pick_tag;

  assign issue    = !req_v_q && q_free && pick_v;
  assign ack_fire = req_v_q && req_ack;
  assign req_en   = issue | ack_fire;
  assign pick_tag = tags[{pick_set, pick_way}*TAG_W +: TAG_W];

  cln_line_state #(.SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_v        (upd_valid),
    .upd_set      (upd_set),
    .upd_way      (upd_way),
    .upd_dirty    (upd_dirty),
    .upd_lru_half (upd_lru_half),
    .upd_tag      (upd_tag),
    .iss_v        (issue),
    .iss_set      (pick_set),
    .iss_way      (pick_way),
    .ack_v        (ack_fire),
    .ack_set      (req_set_q),
    .ack_way      (req_way_q),
    .elig_o       (elig),
    .tag_o        (tags),
    .summary_o    (summary)
  );

  cln_pick #(.SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W),
             .RANK_W(RANK_W), .BANK_W(BANK_W), .CNT_W(CNT_W)) u_pick (
    .elig_i    (elig),
    .tag_i     (tags),
    .summary_i (summary),
    .q_cnt_i   (q_cnt),
    .q_row_i   (q_row),
    .rr_i      (rr_q),
    .pick_v    (pick_v),
    .pick_set  (pick_set),
    .pick_way  (pick_way),
    .pick_tier (pick_tier),
    .pick_rank (pick_rank)
  );

  always_comb begin
    req_v_d   = req_v_q;
    req_set_d = req_set_q;
    req_way_d = req_way_q;
    req_tag_d = req_tag_q;
    rr_d      = rr_q;
    if (ack_fire) begin
      req_v_d = 1'b0;
    end
    if (issue) begin
      req_v_d   = 1'b1;
      req_set_d = pick_set;
      req_way_d = pick_way;
      req_tag_d = pick_tag;
      if (pick_tier == TIER_IDLE) begin
        rr_d = pick_rank + RANK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_v_q   <= 1'b0;
      req_set_q <= '0;
      req_way_q <= '0;
      req_tag_q <= '0;
      rr_q      <= '0;
    end else if (req_en) begin
      req_v_q   <= req_v_d;
      req_set_q <= req_set_d;
      req_way_q <= req_way_d;
      req_tag_q <= req_tag_d;
      rr_q      <= rr_d;
    end
  end

  assign req_valid = req_v_q;
  assign req_set   = req_set_q;
  assign req_way   = req_way_q;
  assign req_addr  = {req_tag_q, req_set_q};

  // Queue view of the chosen line's resource, for the checks below.
  logic [RES_W-1:0] sel_res;
  logic [CNT_W-1:0] sel_cnt;
  logic [TAG_W-1:0] sel_row;
  assign sel_res = pick_set[RES_W-1:0];
  assign sel_cnt = q_cnt[sel_res*CNT_W +: CNT_W];
  assign sel_row = q_row[sel_res*TAG_W +: TAG_W];

  assert_issue_needs_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(q_free));

  assert_hold_until_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_set) && $stable(req_way)
                                 && $stable(req_addr)));

  assert_pick_is_candidate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pick_v |-> elig[{pick_set, pick_way}]);

  assert_no_row_conflict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pick_v |-> ((sel_cnt == '0) || (sel_row == pick_tag)));

  assert_ack_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack) |=> !req_valid);

endmodule

// File: tb/dirty_cleaner_bench.sv
module dirty_cleaner_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_valid, upd_dirty, upd_lru_half;
  logic [3:0]  upd_set, upd_tag;
  logic [1:0]  upd_way;
  logic        q_free, req_ack;
  logic [23:0] q_cnt;
  logic [31:0] q_row;
  logic        req_valid;
  logic [3:0]  req_set;
  logic [1:0]  req_way;
  logic [7:0]  req_addr;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dirty_cleaner u_dirty_cleaner (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_set(upd_set), .upd_way(upd_way),
    .upd_dirty(upd_dirty), .upd_lru_half(upd_lru_half), .upd_tag(upd_tag),
    .q_free(q_free), .q_cnt(q_cnt), .q_row(q_row), .req_ack(req_ack),
    .req_valid(req_valid), .req_set(req_set), .req_way(req_way), .req_addr(req_addr)
  );

  typedef struct packed {
    logic [3:0] a_set; logic [1:0] a_way; logic [3:0] a_tag;
    logic [3:0] b_set; logic [1:0] b_way; logic [3:0] b_tag;
    logic [2:0] q_res; logic [3:0] q_row; logic [2:0] q_n;
    logic       e_v;   logic [3:0] e_set; logic [1:0] e_way;
  } vec_t;

  localparam vec_t TBL [0:8] = '{
    '{4'd1, 2'd0, 4'd5, 4'd2, 2'd1, 4'd3, 3'd2, 4'd3, 3'd1, 1'b1, 4'd2, 2'd1},  // R7 page hit beats idle
    '{4'd5, 2'd0, 4'd7, 4'd4, 2'd2, 4'd1, 3'd5, 4'd2, 3'd2, 1'b1, 4'd4, 2'd2},  // R6 conflict skipped
    '{4'd5, 2'd0, 4'd7, 4'd13,2'd1, 4'd6, 3'd5, 4'd2, 3'd1, 1'b0, 4'd0, 2'd0},  // R11 all conflict
    '{4'd0, 2'd0, 4'd1, 4'd4, 2'd0, 4'd1, 3'd1, 4'd9, 3'd3, 1'b1, 4'd4, 2'd0},  // R8 rank1 lighter
    '{4'd0, 2'd0, 4'd1, 4'd4, 2'd0, 4'd1, 3'd6, 4'd9, 3'd1, 1'b1, 4'd0, 2'd0},  // R8 rank0 lighter
    '{4'd0, 2'd0, 4'd1, 4'd4, 2'd0, 4'd1, 3'd0, 4'd0, 3'd0, 1'b1, 4'd0, 2'd0},  // R9 tie, pointer at 0
    '{4'd9, 2'd3, 4'd2, 4'd1, 2'd0, 4'd2, 3'd0, 4'd0, 3'd0, 1'b1, 4'd1, 2'd0},  // R10 lowest set
    '{4'd3, 2'd2, 4'd5, 4'd3, 2'd1, 4'd5, 3'd0, 4'd0, 3'd0, 1'b1, 4'd3, 2'd1},  // R10 lowest way
    '{4'd10,2'd0, 4'd4, 4'd2, 2'd3, 4'd4, 3'd2, 4'd4, 3'd1, 1'b1, 4'd2, 2'd3}   // R10 among page hits
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; upd_valid = 0; upd_dirty = 0; upd_lru_half = 0;
    upd_set = 0; upd_way = 0; upd_tag = 0;
    q_free = 0; req_ack = 0; q_cnt = '0; q_row = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load(input logic [3:0] s, input logic [1:0] w, input logic [3:0] t,
                      input logic d, input logic l);
    upd_valid = 1; upd_set = s; upd_way = w; upd_tag = t; upd_dirty = d; upd_lru_half = l;
    @(negedge clk);
    upd_valid = 0;
  endtask

  task automatic set_queue(input logic [2:0] res, input logic [3:0] row, input logic [2:0] n);
    q_cnt = '0; q_row = '0;
    q_cnt[res*3 +: 3] = n;
    q_row[res*4 +: 4] = row;
  endtask

  task automatic ack();
    req_ack = 1;
    @(negedge clk);
    req_ack = 0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (any requirement): actual timeout expected completion");
    report();
  end

  initial begin
    // R1: reset state
    do_reset();
    chk("R1 valid after reset", int'(req_valid), 0);
    q_free = 1;
    @(negedge clk); @(negedge clk);
    chk("R1 no request when nothing dirty", int'(req_valid), 0);

    // Selection table
    foreach (TBL[i]) begin
      do_reset();
      load(TBL[i].a_set, TBL[i].a_way, TBL[i].a_tag, 1, 1);
      load(TBL[i].b_set, TBL[i].b_way, TBL[i].b_tag, 1, 1);
      set_queue(TBL[i].q_res, TBL[i].q_row, TBL[i].q_n);
      q_free = 1;
      @(negedge clk);
      chk($sformatf("table %0d valid", i), int'(req_valid), int'(TBL[i].e_v));
      if (TBL[i].e_v) begin
        chk($sformatf("table %0d set", i), int'(req_set), int'(TBL[i].e_set));
        chk($sformatf("table %0d way", i), int'(req_way), int'(TBL[i].e_way));
      end
    end

    // R2: MRU-side dirty and LRU-side clean lines are ignored
    do_reset();
    q_free = 1;
    load(4'd0, 2'd0, 4'd1, 1, 0);
    @(negedge clk);
    chk("R2 MRU-half dirty ignored", int'(req_valid), 0);
    load(4'd0, 2'd1, 4'd1, 0, 1);
    @(negedge clk);
    chk("R2 clean line ignored", int'(req_valid), 0);
    load(4'd0, 2'd0, 4'd1, 1, 1);
    @(negedge clk);
    chk("R2 LRU-half dirty requested", int'(req_valid), 1);
    chk("R2 way", int'(req_way), 0);

    // R3/R4/R5: closed queue, hold, acceptance
    do_reset();
    load(4'd6, 2'd1, 4'hA, 1, 1);
    @(negedge clk); @(negedge clk);
    chk("R3 no issue without free slot", int'(req_valid), 0);
    q_free = 1;
    @(negedge clk);
    chk("R3 issue once slot free", int'(req_valid), 1);
    chk("R4 address is tag,set", int'(req_addr), 8'hA6);
    load(4'd7, 2'd0, 4'h3, 1, 1);
    @(negedge clk); @(negedge clk);
    chk("R3 single outstanding, set held", int'(req_set), 6);
    chk("R4 way held", int'(req_way), 1);
    chk("R4 address held", int'(req_addr), 8'hA6);
    ack();
    chk("R5 valid drops after accept", int'(req_valid), 0);
    @(negedge clk);
    chk("R5 next line set", int'(req_set), 7);
    ack();
    @(negedge clk); @(negedge clk);
    chk("R5 accepted lines not re-requested (R11)", int'(req_valid), 0);

    // R9: rank rotation over four idle-bank lines
    do_reset();
    load(4'd0, 2'd0, 4'd2, 1, 1);
    load(4'd1, 2'd0, 4'd2, 1, 1);
    load(4'd4, 2'd0, 4'd2, 1, 1);
    load(4'd5, 2'd0, 4'd2, 1, 1);
    q_free = 1;
    @(negedge clk);
    chk("R9 first pick rank0 set", int'(req_set), 0);
    ack(); @(negedge clk);
    chk("R9 second pick rank1 set", int'(req_set), 4);
    ack(); @(negedge clk);
    chk("R9 third pick rank0 set", int'(req_set), 1);
    ack(); @(negedge clk);
    chk("R9 fourth pick rank1 set", int'(req_set), 5);

    report();
  end

endmodule